// File: doc/BRIEF.md
# Byte-Moving DMA Channel Sequencer

This block is a single direct-memory-access channel engine. It copies bytes from a source region to a destination region of a byte-addressed data space over a shared bus, one read followed by one write per byte. Software sets up a start address, a stepping mode and a reload point for each side, plus a burst size, a block length and a block repeat count. It then fires a trigger, either with a one-cycle software strobe or from a selected external event line.

Work is nested in three levels. Bursts of 1, 2, 4 or 8 bytes run without a break in the bus request. Bursts make up a block of up to 65535 bytes, and the block runs 1 to 255 times to form one transaction. In single-shot mode every trigger moves a single burst. Otherwise one trigger runs the whole transaction, and a trigger that arrives during the run is held and starts the next transaction. A busy level and a one-cycle done pulse report progress. The working addresses take the configured start values while reset is high, and again at the reload points chosen for each side.

Top module: `dma_chan_seq`

## Requirements
- R1: Each byte is read from the current source address (bus_re high with bus_ready) and then written to the current destination address (bus_we high with bus_ready) with the same data value. Read and write strobes are never high together.
- R2: Mode code per side: 0 holds the address, 1 adds one, 2 subtracts one. The step is applied after every byte written.
- R3: Burst code 0, 1, 2, 3 gives bursts of 1, 2, 4, 8 bytes. bus_req stays high for a whole burst and falls only in the cycle after the write that ends a burst.
- R4: Block length (1 to 65535, 0 treated as 1) sets the bytes per block. A burst is cut short at the end of a block.
- R5: Repeat count (1 to 255, 0 treated as 1) sets the blocks per transaction.
- R6: Reload code per side: 0 never, 1 after each burst, 2 after each block, 3 after the transaction. A reload restores the start address in place of the step. While rst is high both working addresses take their start values, and with code 0 the next transaction continues from where the last one stopped.
- R7: A trigger is a cycle with sw_trig high, or a rising edge of evt_in while evt_en is high. With evt_en low, evt_in has no effect, and a level held high counts once.
- R8: With single_shot high, each trigger moves exactly one burst. The channel then idles with busy held high until the next trigger.
- R9: busy rises in the cycle after the starting trigger. In the cycle after the last write of the transaction, busy falls and done is high for exactly one cycle.
- R10: When single_shot is low, a trigger arriving while the channel is busy is stored. It starts a new transaction once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_mode | input | 2 | Source stepping mode |
| cfg_dst_mode | input | 2 | Destination stepping mode |
| cfg_src_reload | input | 2 | Source reload point |
| cfg_dst_reload | input | 2 | Destination reload point |
| cfg_burst | input | 2 | Burst size code |
| cfg_block_len | input | BLK_W | Bytes per block |
| cfg_repeat | input | REP_W | Blocks per transaction |
| cfg_single | input | 1 | Single-shot mode |
| cfg_evt_en | input | 1 | Enable for the event trigger |
| sw_trig | input | 1 | Software trigger strobe |
| evt_in | input | 1 | External event line |
| bus_req | output | 1 | Bus request, held over a burst |
| bus_grant | input | 1 | Bus grant |
| bus_re | output | 1 | Read strobe |
| bus_we | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle transaction-end pulse |

## Verification
A trigger sampled on one edge raises busy on that edge. The earliest read is one cycle later, since the channel first spends a cycle requesting the bus. Each byte costs at least two cycles, and the done pulse comes one cycle after the final write. Bursts are also separated by one request-free cycle. Because bus stalls make absolute latencies vary, the checks count bus handshakes, request falls and done pulses as they happen, and compare those counts and the memory image at falling edges. Those comparisons are made either after a done pulse or after a fixed wait that is long enough for any single burst to finish.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        RLD_NEVER = 2'd0,
        RLD_BURST = 2'd1,
        RLD_BLOCK = 2'd2,
        RLD_XACT  = 2'd3
    } reload_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_REQ,
        ST_RD,
        ST_WR
    } state_e;

    typedef struct packed {
        logic burst_end;
        logic block_end;
        logic xact_end;
    } bound_t;

    localparam int BEAT_W = 4;

    function automatic logic [BEAT_W-1:0] burst_bytes(input logic [1:0] code);
        return BEAT_W'(1) << code;
    endfunction

endpackage

// File: rtl/dma_trig_unit.sv
module dma_trig_unit (
    input  logic clk,
    input  logic rst,
    input  logic sw_trig,
    input  logic evt_in,
    input  logic evt_en,
    input  logic latch_en,
    input  logic take,
    output logic fire,
    output logic pend
);
    logic evt_q;

    assign fire = sw_trig | (evt_en & evt_in & ~evt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            evt_q <= evt_in;
            if (fire && latch_en)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
    import dma_seq_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic [1:0]       burst_code,
    input  logic [BLK_W-1:0] block_len,
    input  logic [REP_W-1:0] rep_total,
    output bound_t           bnd
);
    logic [BEAT_W-1:0] beat;
    logic [BLK_W-1:0]  byte_i;
    logic [REP_W-1:0]  rep_i;

    always_comb begin
        bnd.block_end = ({1'b0, byte_i} + (BLK_W+1)'(1)) >= {1'b0, block_len};
        bnd.xact_end  = bnd.block_end &&
                        (({1'b0, rep_i} + (REP_W+1)'(1)) >= {1'b0, rep_total});
        bnd.burst_end = bnd.block_end ||
                        ((beat + BEAT_W'(1)) == burst_bytes(burst_code));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat   <= '0;
            byte_i <= '0;
            rep_i  <= '0;
        end else if (adv) begin
            beat <= bnd.burst_end ? '0 : beat + BEAT_W'(1);
            if (bnd.block_end) begin
                byte_i <= '0;
                rep_i  <= bnd.xact_end ? '0 : rep_i + REP_W'(1);
            end else begin
                byte_i <= byte_i + BLK_W'(1);
            end
        end
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] start,
    input  logic [1:0]    mode,
    input  logic [1:0]    rld,
    input  logic          adv,
    input  bound_t        bnd,
    output logic [AW-1:0] addr
);
    step_e         m;
    reload_e       r;
    logic          hit;
    logic [AW-1:0] stepped;

    assign m = step_e'(mode);
    assign r = reload_e'(rld);

    always_comb begin
        unique case (r)
            RLD_BURST: hit = bnd.burst_end;
            RLD_BLOCK: hit = bnd.block_end;
            RLD_XACT:  hit = bnd.xact_end;
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (m)
            STEP_UP:   stepped = addr + AW'(1);
            STEP_DOWN: stepped = addr - AW'(1);
            default:   stepped = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= start;
        else if (adv)
            addr <= hit ? start : stepped;
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int BLK_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_src_addr,
    input  logic [AW-1:0]    cfg_dst_addr,
    input  logic [1:0]       cfg_src_mode,
    input  logic [1:0]       cfg_dst_mode,
    input  logic [1:0]       cfg_src_reload,
    input  logic [1:0]       cfg_dst_reload,
    input  logic [1:0]       cfg_burst,
    input  logic [BLK_W-1:0] cfg_block_len,
    input  logic [REP_W-1:0] cfg_repeat,
    input  logic             cfg_single,
    input  logic             cfg_evt_en,
    input  logic             sw_trig,
    input  logic             evt_in,
    output logic             bus_req,
    input  logic             bus_grant,
    output logic             bus_re,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready,
    output logic             busy,
    output logic             done
);
    localparam int NSIDE = 2;

    state_e        st;
    logic          fire, pend, start, adv;
    bound_t        bnd;
    logic [DW-1:0] data_q;

    logic [AW-1:0] side_start [NSIDE];
    logic [1:0]    side_mode  [NSIDE];
    logic [1:0]    side_rld   [NSIDE];
    logic [AW-1:0] side_addr  [NSIDE];

    assign side_start[0] = cfg_src_addr;
    assign side_start[1] = cfg_dst_addr;
    assign side_mode[0]  = cfg_src_mode;
    assign side_mode[1]  = cfg_dst_mode;
    assign side_rld[0]   = cfg_src_reload;
    assign side_rld[1]   = cfg_dst_reload;

    assign start = (st == ST_IDLE) && (fire || pend);
    assign adv   = (st == ST_WR) && bus_ready;

    dma_trig_unit u_trig (
        .clk      (clk),
        .rst      (rst),
        .sw_trig  (sw_trig),
        .evt_in   (evt_in),
        .evt_en   (cfg_evt_en),
        .latch_en ((st != ST_IDLE) && !cfg_single),
        .take     (start),
        .fire     (fire),
        .pend     (pend)
    );

    dma_xfer_count #(.BLK_W(BLK_W), .REP_W(REP_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .adv        (adv),
        .burst_code (cfg_burst),
        .block_len  (cfg_block_len),
        .rep_total  (cfg_repeat),
        .bnd        (bnd)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_step #(.AW(AW)) u_addr (
            .clk   (clk),
            .rst   (rst),
            .start (side_start[g]),
            .mode  (side_mode[g]),
            .rld   (side_rld[g]),
            .adv   (adv),
            .bnd   (bnd),
            .addr  (side_addr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b0;
            data_q <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_REQ;
                    busy <= 1'b1;
                end
                ST_GAP: if (!cfg_single || fire) st <= ST_REQ;
                ST_REQ: if (bus_grant) st <= ST_RD;
                ST_RD: if (bus_ready) begin
                    data_q <= bus_rdata;
                    st     <= ST_WR;
                end
                ST_WR: if (bus_ready) begin
                    if (bnd.xact_end) begin
                        st   <= ST_IDLE;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else if (bnd.burst_end) begin
                        st <= ST_GAP;
                    end else begin
                        st <= ST_RD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
    assign bus_re    = (st == ST_RD);
    assign bus_we    = (st == ST_WR);
    assign bus_addr  = (st == ST_WR) ? side_addr[1] : side_addr[0];
    assign bus_wdata = data_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_re,
    input logic          bus_we,
    input logic          bus_ready,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] bus_wdata,
    input logic          busy,
    input logic          done
);
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(bus_re && bus_we)); // R1
    AST_WDATA_MATCHES_READ: assert property (@(posedge clk) disable iff (rst) (bus_we && $past(bus_re && bus_ready)) |-> bus_wdata == $past(bus_rdata)); // R1
    AST_STROBE_UNDER_REQ: assert property (@(posedge clk) disable iff (rst) (bus_re || bus_we) |-> bus_req); // R3
    AST_REQ_FALLS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) $fell(bus_req) |-> $past(bus_we && bus_ready)); // R3
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) !busy |-> !bus_req); // R9
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
    logic [1:0]  cfg_src_reload = '0, cfg_dst_reload = '0;
    logic [1:0]  cfg_burst = '0;
    logic [15:0] cfg_block_len = 16'd1;
    logic [7:0]  cfg_repeat = 8'd1;
    logic        cfg_single = 1'b0, cfg_evt_en = 1'b0;
    logic        sw_trig = 1'b0, evt_in = 1'b0;
    logic        bus_req, bus_grant, bus_re, bus_we, bus_ready, busy, done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        grant_on = 1'b1, stall_en = 1'b0, stall_t = 1'b0;

    logic [7:0]  mem [256];
    int          wr_cnt, done_cnt, nseg, seg_cnt;
    int          seg_log [16];
    logic [7:0]  wa_log [64];
    logic [7:0]  wd_log [64];
    logic        req_q;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    dma_chan_seq uut (
        .clk(clk), .rst(rst),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_src_reload(cfg_src_reload), .cfg_dst_reload(cfg_dst_reload),
        .cfg_burst(cfg_burst), .cfg_block_len(cfg_block_len), .cfg_repeat(cfg_repeat),
        .cfg_single(cfg_single), .cfg_evt_en(cfg_evt_en),
        .sw_trig(sw_trig), .evt_in(evt_in),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_re(bus_re), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .busy(busy), .done(done)
    );

    function automatic logic [7:0] fval(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign bus_grant = bus_req & grant_on;
    assign bus_ready = (bus_re | bus_we) & (stall_en ? stall_t : 1'b1);
    assign bus_rdata = mem[bus_addr[7:0]];

    always @(posedge clk) begin
        stall_t <= ~stall_t;
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= fval(i);
            wr_cnt <= 0; done_cnt <= 0; nseg <= 0; seg_cnt <= 0; req_q <= 1'b0;
        end else begin
            req_q <= bus_req;
            if (bus_we && bus_ready) begin
                mem[bus_addr[7:0]] <= bus_wdata;
                wa_log[wr_cnt & 63] <= bus_addr[7:0];
                wd_log[wr_cnt & 63] <= bus_wdata;
                wr_cnt  <= wr_cnt + 1;
                seg_cnt <= seg_cnt + 1;
            end
            if (req_q && !bus_req) begin
                seg_log[nseg & 15] <= seg_cnt;
                nseg    <= nseg + 1;
                seg_cnt <= 0;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int src, input int dst, input int sm, input int dm,
                           input int sr, input int dr, input int bc, input int bl, input int rp);
        cfg_src_addr = 16'(src); cfg_dst_addr = 16'(dst);
        cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm);
        cfg_src_reload = 2'(sr); cfg_dst_reload = 2'(dr);
        cfg_burst = 2'(bc); cfg_block_len = 16'(bl); cfg_repeat = 8'(rp);
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic wait_done(input int n);
        for (int c = 0; c < 3000 && done_cnt < n; c++) @(negedge clk);
    endtask

    task automatic t_reset();
        cfg_single = 0; cfg_evt_en = 0; stall_en = 0;
        set_cfg(0, 'h80, 1, 1, 0, 0, 0, 1, 1);
        do_reset();
        chk(!busy && !done && !bus_req, "R9 reset idle", {busy, done, bus_req}, 0);
    endtask

    task automatic t_copy_inc();
        bit ok = 1;
        set_cfg('h10, 'h80, 1, 1, 0, 0, 2, 6, 1);
        stall_en = 1;
        do_reset();
        pulse_sw();
        chk(busy == 1'b1, "R9 busy after trigger", busy, 1);
        wait_done(1);
        for (int i = 0; i < 6; i++) if (mem['h80 + i] != fval('h10 + i)) ok = 0;
        chk(ok, "R1 R2 incrementing copy", mem['h85], fval('h15));
        chk(mem['h86] == fval('h86), "R4 block length limit", mem['h86], fval('h86));
        chk(nseg == 2 && seg_log[0] == 4 && seg_log[1] == 2, "R3 R4 burst split 4+2",
            nseg * 100 + seg_log[0] * 10 + seg_log[1], 242);
        chk(done_cnt == 1 && !busy, "R9 single done pulse", done_cnt, 1);
        stall_en = 0;
    endtask

    task automatic t_dec_hold();
        bit ok = 1;
        set_cfg('h30, 'h90, 2, 0, 0, 0, 3, 5, 1);
        do_reset();
        pulse_sw();
        wait_done(1);
        for (int i = 0; i < 5; i++)
            if (wa_log[i] != 8'h90 || wd_log[i] != fval('h30 - i)) ok = 0;
        chk(ok && wr_cnt == 5, "R2 decrement source, hold destination", wr_cnt, 5);
        chk(mem['h90] == fval('h2C), "R2 held destination keeps last byte", mem['h90], fval('h2C));
    endtask

    task automatic t_reload_burst();
        bit ok = 1;
        set_cfg('h20, 'hA0, 1, 1, 1, 0, 1, 6, 1);
        do_reset();
        pulse_sw();
        wait_done(1);
        for (int i = 0; i < 6; i++) if (mem['hA0 + i] != fval('h20 + (i % 2))) ok = 0;
        chk(ok, "R6 source reload per burst", mem['hA2], fval('h20));
    endtask

    task automatic t_repeat_block();
        bit ok = 1;
        set_cfg('h00, 'hB0, 1, 1, 2, 0, 3, 3, 3);
        do_reset();
        pulse_sw();
        wait_done(1);
        for (int i = 0; i < 9; i++) if (mem['hB0 + i] != fval(i % 3)) ok = 0;
        chk(ok && wr_cnt == 9, "R5 R6 three blocks with block reload", wr_cnt, 9);
        chk(nseg == 3, "R4 block end closes burst", nseg, 3);
    endtask

    task automatic t_reload_never();
        set_cfg('h08, 'hC0, 1, 1, 0, 3, 0, 2, 1);
        do_reset();
        pulse_sw();
        wait_done(1);
        pulse_sw();
        wait_done(2);
        chk(mem['hC0] == fval('h0A) && mem['hC1] == fval('h0B), "R6 source continues, destination reloads",
            mem['hC0], fval('h0A));
        chk(mem['hC2] == fval('hC2), "R6 destination reloaded at transaction end", mem['hC2], fval('hC2));
    endtask

    task automatic t_single();
        set_cfg('h00, 'hD0, 1, 1, 0, 0, 1, 6, 1);
        cfg_single = 1;
        do_reset();
        pulse_sw();
        repeat (20) @(negedge clk);
        chk(wr_cnt == 2 && busy, "R8 one burst per trigger", wr_cnt, 2);
        pulse_sw();
        repeat (20) @(negedge clk);
        chk(wr_cnt == 4 && done_cnt == 0, "R8 second burst", wr_cnt, 4);
        pulse_sw();
        wait_done(1);
        chk(wr_cnt == 6 && !busy && mem['hD5] == fval(5), "R8 R9 last burst ends transaction", wr_cnt, 6);
        cfg_single = 0;
    endtask

    task automatic t_event();
        set_cfg('h00, 'hE8, 1, 1, 0, 0, 3, 3, 1);
        cfg_evt_en = 0;
        do_reset();
        evt_in = 1;
        repeat (2) @(negedge clk);
        evt_in = 0;
        repeat (10) @(negedge clk);
        chk(wr_cnt == 0 && !busy, "R7 event ignored when disabled", wr_cnt, 0);
        cfg_evt_en = 1;
        evt_in = 1;
        wait_done(1);
        repeat (15) @(negedge clk);
        chk(wr_cnt == 3 && done_cnt == 1, "R7 held event counts once", wr_cnt, 3);
        evt_in = 0;
        cfg_evt_en = 0;
    endtask

    task automatic t_pending();
        set_cfg('h00, 'hE0, 1, 1, 3, 3, 0, 4, 1);
        do_reset();
        pulse_sw();
        repeat (3) @(negedge clk);
        pulse_sw();
        wait_done(2);
        repeat (5) @(negedge clk);
        chk(done_cnt == 2 && wr_cnt == 8, "R10 stored trigger runs second transaction", wr_cnt, 8);
        chk(!busy, "R10 idle after second transaction", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_copy_inc();
        t_dec_hold();
        t_reload_burst();
        t_repeat_block();
        t_reload_never();
        t_single();
        t_event();
        t_pending();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule